// File: doc/BRIEF.md
# Vector Narrowing Right Shifter

This block narrows a fixed-length vector by shifting each double-width unsigned element right and keeping the low half. A 6-bit control word arrives with each vector. It is made of a 3-bit size code and a 3-bit immediate. The block decodes the destination element width (8, 16 or 32 bits) and the shift amount from that word. Each narrowed result is written to an even half-width lane, and every odd lane is cleared. All lanes are written on every transfer, and no lane is ever masked.

Operands enter through a valid/ready stream and leave through a second valid/ready stream with one register stage. An input is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result and its flag are held unchanged, and no new input is taken. A size code of zero is an illegal encoding. It produces an all-zero result with `out_undef` raised, and the result still moves through the stream normally.

Top module: `vec_narrow_shr`

## Requirements
- R1: A size code {sz_top, sz_low} of 3'b000 produces dst_vec equal to all zeros with out_undef high. Any other size code gives out_undef low.
- R2: The destination lane width EW is decoded from the size code as follows: 3'b001 gives 8, 3'b010 or 3'b011 gives 16, and 3'b1xx gives 32. Each source element is 2*EW bits wide.
- R3: The shift amount is 2*EW minus the unsigned 6-bit value {sz_top, sz_low, imm_lo}. For every legal code this lies between 1 and EW.
- R4: Each source element is shifted right logically, with zeros filling in from the top. The result is truncated to its low EW bits.
- R5: The result for source element e (bits [2e*EW +: 2*EW] of src_vec) is placed in destination lane 2e, which is bits [2e*EW +: EW]. Lane 2e+1 is all zeros.
- R6: All VLEN/(2*EW) source elements are processed on every transfer, with no masking.
- R7: An input is accepted when in_valid and in_ready are both high. in_ready is low while out_valid is high and out_ready is low.
- R8: A result becomes visible with out_valid high in the clock cycle right after its input is accepted.
- R9: While out_valid is high and out_ready is low, out_valid, dst_vec and out_undef keep their values.
- R10: A synchronous, active-high rst clears out_valid, dst_vec and out_undef.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operand is presented |
| in_ready | output | 1 | The block can take an operand |
| src_vec | input | VLEN | Source vector of double-width elements |
| sz_top | input | 1 | High bit of the size code |
| sz_low | input | 2 | Low bits of the size code |
| imm_lo | input | 3 | Low immediate bits of the shift encoding |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the result |
| dst_vec | output | VLEN | Narrowed result vector |
| out_undef | output | 1 | Result came from an illegal size code |

## Verification
A wrong width decode or a wrong shift amount shows up in dst_vec on the very next output beat. The lane pattern moves or the wrong bits are kept, and this is clearest when the vector is all ones and both the smallest and largest shift are used. A stale or corrupted output register shows up as a value that changes during a stall, or as a beat that is lost or repeated. The ordered scoreboard catches either case at the first transfer that follows. A broken acceptance condition shows at the ports as an operand taken during a stall, and the stall check flags that in the same cycle.

// File: rtl/vns_pkg.sv
package vns_pkg;

  typedef enum logic [1:0] {
    ESZ_NONE = 2'd0,
    ESZ_B8   = 2'd1,
    ESZ_B16  = 2'd2,
    ESZ_B32  = 2'd3
  } esz_e;

  localparam int unsigned NUM_WIDTHS = 3;
  localparam int unsigned SHAMT_W    = 6;

  function automatic int unsigned lane_bits(input esz_e sel);
    case (sel)
      ESZ_B8:  return 8;
      ESZ_B16: return 16;
      ESZ_B32: return 32;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/vns_decode.sv
module vns_decode
  import vns_pkg::*;
(
  input  logic [2:0]         size_code,
  input  logic [2:0]         imm_bits,
  output esz_e               esel,
  output logic [SHAMT_W-1:0] shamt,
  output logic               illegal
);

  logic [6:0] enc_val;
  logic [6:0] span;
  logic [6:0] diff;

  assign enc_val = {1'b0, size_code, imm_bits};

  always_comb begin
    if (size_code[2])      esel = ESZ_B32;
    else if (size_code[1]) esel = ESZ_B16;
    else if (size_code[0]) esel = ESZ_B8;
    else                   esel = ESZ_NONE;
  end

  always_comb begin
    case (esel)
      ESZ_B8:  span = 7'd16;
      ESZ_B16: span = 7'd32;
      ESZ_B32: span = 7'd64;
      default: span = 7'd0;
    endcase
  end

  assign diff    = span - enc_val;
  assign illegal = (esel == ESZ_NONE);
  assign shamt   = illegal ? '0 : diff[SHAMT_W-1:0];

  // R3: legal codes always decode to a shift in 1..EW
  always_comb begin
    if (!illegal) begin
      a_r3_shift_range: assert (shamt >= 1 && 32'(shamt) <= lane_bits(esel))
        else $error("shift %0d outside 1..%0d", shamt, lane_bits(esel));
    end
  end

endmodule

// File: rtl/vns_narrow_bank.sv
module vns_narrow_bank
  import vns_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned EW   = 8
) (
  input  logic [VLEN-1:0]    src,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [VLEN-1:0]    res
);

  localparam int unsigned SW    = 2 * EW;
  localparam int unsigned NELEM = VLEN / SW;

  for (genvar e = 0; e < NELEM; e++) begin : g_elem
    logic [SW-1:0] elem;
    logic [SW-1:0] shifted;
    logic [EW-1:0] kept;
    assign elem    = src[e*SW +: SW];
    assign shifted = elem >> shamt;
    assign kept    = shifted[EW-1:0];
    assign res[e*SW +: SW] = {{EW{1'b0}}, kept};
  end

  if (VLEN % SW != 0) begin : g_tail
    assign res[VLEN-1:NELEM*SW] = '0;
  end

endmodule

// File: rtl/vns_out_stage.sv
module vns_out_stage #(
  parameter int unsigned W = 129
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic         full_q;
  logic [W-1:0] data_q;
  logic         take;

  assign up_ready = !full_q || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) begin
        full_q <= 1'b1;
        data_q <= up_data;
      end else if (dn_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;

  a_r8_next_cycle: assert property (@(posedge clk) disable iff (rst)
    up_valid && up_ready |=> dn_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> !dn_valid && dn_data == '0);

endmodule

// File: rtl/vec_narrow_shr.sv
module vec_narrow_shr
  import vns_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VLEN-1:0] src_vec,
  input  logic            sz_top,
  input  logic [1:0]      sz_low,
  input  logic [2:0]      imm_lo,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] dst_vec,
  output logic            out_undef
);

  localparam int unsigned PW = VLEN + 1;

  esz_e               esel;
  logic [SHAMT_W-1:0] shamt;
  logic               illegal;
  logic [VLEN-1:0]    bank_res [NUM_WIDTHS];
  logic [VLEN-1:0]    picked;
  logic [PW-1:0]      pay_in;
  logic [PW-1:0]      pay_out;

  vns_decode u_dec (
    .size_code (({sz_top, sz_low})),
    .imm_bits  (imm_lo),
    .esel      (esel),
    .shamt     (shamt),
    .illegal   (illegal)
  );

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_bank
    vns_narrow_bank #(
      .VLEN (VLEN),
      .EW   (8 << g)
    ) u_bank (
      .src   (src_vec),
      .shamt (shamt),
      .res   (bank_res[g])
    );
  end

  always_comb begin
    case (esel)
      ESZ_B8:  picked = bank_res[0];
      ESZ_B16: picked = bank_res[1];
      ESZ_B32: picked = bank_res[2];
      default: picked = '0;
    endcase
  end

  assign pay_in = {illegal, picked};

  vns_out_stage #(.W(PW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign dst_vec   = pay_out[VLEN-1:0];
  assign out_undef = pay_out[VLEN];

  a_r1_undef_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_undef |-> dst_vec == '0);

  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && in_valid |=> $stable(dst_vec) && $stable(out_undef));

endmodule

// File: tb/tb_vec_narrow_shr.sv
module tb_vec_narrow_shr;

  localparam int VLEN = 128;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [VLEN-1:0] src_vec = '0;
  logic            sz_top = 1'b0;
  logic [1:0]      sz_low = 2'b00;
  logic [2:0]      imm_lo = 3'b000;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [VLEN-1:0] dst_vec;
  logic            out_undef;

  int checks = 0;
  int errors = 0;
  bit stop_mon = 0;
  bit bp_on = 0;

  logic [VLEN:0] sb_q [$];

  vec_narrow_shr #(.VLEN(VLEN)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_vec(src_vec), .sz_top(sz_top), .sz_low(sz_low), .imm_lo(imm_lo),
    .out_valid(out_valid), .out_ready(out_ready), .dst_vec(dst_vec),
    .out_undef(out_undef)
  );

  always #10 clk = ~clk;

  function automatic logic [VLEN:0] model(input logic [VLEN-1:0] s,
                                          input logic [2:0] sz,
                                          input logic [2:0] im);
    logic [VLEN-1:0] r;
    int ew, sh;
    r = '0;
    if (sz == 3'b000) return {1'b1, r};
    if (sz[2]) ew = 32; else if (sz[1]) ew = 16; else ew = 8;
    sh = 2 * ew - int'({sz, im});
    for (int e = 0; e < VLEN / (2 * ew); e++)
      for (int b = 0; b < ew; b++)
        if (b + sh < 2 * ew) r[e*2*ew + b] = s[e*2*ew + b + sh];
    return {1'b0, r};
  endfunction

  task automatic check(input bit ok, input string req, input logic [VLEN:0] act,
                       input logic [VLEN:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [VLEN-1:0] s, input logic [2:0] sz,
                      input logic [2:0] im);
    bit done = 0;
    @(negedge clk);
    in_valid = 1'b1; src_vec = s; {sz_top, sz_low} = sz; imm_lo = im;
    while (!done) begin
      #1;
      if (in_ready) begin
        sb_q.push_back(model(s, sz, im));
        done = 1;
      end
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  // backpressure driver, changes only just after a rising edge
  always @(posedge clk) begin
    #2;
    if (bp_on) out_ready = ($urandom % 3) != 0;
    else out_ready = 1'b1;
  end

  // monitor / scoreboard
  logic          prev_stall = 0;
  logic [VLEN:0] prev_val;
  always @(negedge clk) begin
    if (!rst && !stop_mon) begin
      if (prev_stall)
        check(out_valid && {out_undef, dst_vec} == prev_val, "R9 hold",
              {out_undef, dst_vec}, prev_val);
      if (out_valid && !out_ready)
        check(!in_ready, "R7 stall ready", {{VLEN{1'b0}}, in_ready}, '0);
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0)
          check(0, "R6 unexpected beat", {out_undef, dst_vec}, '0);
        else begin
          logic [VLEN:0] exp;
          exp = sb_q.pop_front();
          check({out_undef, dst_vec} == exp, "R1-5 data R2 R3 R4 R5 R6",
                {out_undef, dst_vec}, exp);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_val = {out_undef, dst_vec};
    end
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] ones;
    ones = '1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!out_valid && !out_undef && dst_vec == '0, "R10 reset",
          {out_undef, dst_vec}, '0);

    // R8 latency with consumer always ready
    send({4{32'hA5C3_9F01}}, 3'b001, 3'b111);
    @(negedge clk);
    check(out_valid, "R8 latency", {{VLEN{1'b0}}, out_valid}, 1);

    // R1 illegal size code for every immediate
    for (int im = 0; im < 8; im++) send({4{$urandom}}, 3'b000, 3'(im));

    // R3/R4 min and max shift per width with all-ones and pattern vectors
    for (int sz = 1; sz < 8; sz++) begin
      send(ones, 3'(sz), 3'b000);
      send(ones, 3'(sz), 3'b111);
      send({16{8'h81}}, 3'(sz), 3'b000);
      send({16{8'h81}}, 3'(sz), 3'b111);
    end

    // R2/R5/R6 sweep every legal code with random vectors
    for (int sz = 1; sz < 8; sz++)
      for (int im = 0; im < 8; im++)
        repeat (2) send({$urandom, $urandom, $urandom, $urandom}, 3'(sz), 3'(im));

    // R7/R9 same sweep under backpressure
    bp_on = 1;
    for (int sz = 0; sz < 8; sz++)
      for (int im = 0; im < 8; im++)
        send({$urandom, $urandom, $urandom, $urandom}, 3'(sz), 3'(im));
    bp_on = 0;

    repeat (10) @(posedge clk);
    check(sb_q.size() == 0, "R6 all beats delivered",
          (VLEN+1)'(sb_q.size()), '0);

    // R10 reset while holding a result
    bp_on = 1;
    send(ones, 3'b100, 3'b000);
    @(negedge clk);
    stop_mon = 1;
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_undef && dst_vec == '0, "R10 reset mid stream",
          {out_undef, dst_vec}, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule